// File: doc/BRIEF.md
# Seconds-Tick Rate Trimmer

This block sits between a raw one-pulse-per-second source and a seconds counter. It corrects a slow or fast timebase by skipping or doubling a whole second every N raw seconds. Software sets the correction with one 32-bit adjust word. That word carries an enable bit, a two-bit direction code and a 19-bit match count. The correction recurs every match + 1 raw seconds, so the trim is 1e9/(match+1) parts per billion. A period of one second (match = 0) gives the coarsest trim, and the full field width gives the finest.

For every raw tick the block issues exactly one outcome to the counter, one cycle later. The outcome is a single-step strobe (add one second), a double-step strobe (add two seconds), or nothing (the second is dropped). Each write to the adjust word restarts the period count. The counter and the clock source are outside this block.

Top module: `sec_trim_top`

## Requirements
- R1: After reset both strobes are low and the block is inactive, so the first tick gives a single step and the period count is zero.
- R2: The adjust word is taken only when the write strobe is high with byte address 0x18. In that word, bits 18:0 are the match count, bits 20:19 are the direction code and bit 23 is the enable. Writes to any other address have no effect, and so do all other bits.
- R3: With the enable at 0, every tick gives a single step and never a double step or a dropped second.
- R4: With the enable at 1 and direction code 0 or 1, every tick gives a single step.
- R5: With the enable at 1 and direction code 2, the tick that completes each run of match + 1 ticks since the last write gives no step. Every other tick gives a single step.
- R6: With the enable at 1 and direction code 3, the tick that completes each run of match + 1 ticks since the last write gives a double step and no single step. Every other tick gives a single step.
- R7: A match count of 0 corrects every tick, and a match count of 0x7FFFF corrects none of the first ticks after the write. The period count never exceeds the match count.
- R8: A write to the adjust word resets the period count to zero. A tick in the same cycle as that write gives a single step and is not counted.
- R9: The strobes are single-cycle pulses in the cycle after a tick. They are never high together and are never high without a tick in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | Raw one-second pulse, one clock wide |
| adj_we | input | 1 | Adjust word write strobe |
| adj_addr | input | 8 | Byte address of the write |
| adj_wdata | input | 32 | Write data |
| step_one | output | 1 | Advance the seconds counter by one |
| step_two | output | 1 | Advance the seconds counter by two |

## Verification
The assertions assume that `sec_tick` is a single-cycle pulse and that two ticks never fall on back-to-back cycles. The real source ticks once per second, far slower than the block clock. The bench keeps to this by always putting at least one idle cycle between ticks. It also keeps every write to a single cycle. Coincident write-and-tick happens only in the dedicated R8 scenario, where the strobe outcome is still defined.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;

  localparam int MATCH_W   = 19;
  localparam int DIR_LSB   = 19;
  localparam int EN_BIT    = 23;
  localparam int WORD_W    = 32;

  typedef enum logic [1:0] {
    DIR_OFF0 = 2'd0,
    DIR_OFF1 = 2'd1,
    DIR_DROP = 2'd2,
    DIR_ADD  = 2'd3
  } trim_dir_e;

  typedef struct packed {
    logic                 en;
    trim_dir_e            dir;
    logic [MATCH_W-1:0]   match;
  } trim_cfg_t;

  // Pull the three fields out of a raw bus word.
  function automatic trim_cfg_t unpack_word(input logic [WORD_W-1:0] w);
    trim_cfg_t c;
    c.en    = w[EN_BIT];
    c.dir   = trim_dir_e'(w[DIR_LSB+1:DIR_LSB]);
    c.match = w[MATCH_W-1:0];
    return c;
  endfunction

  // Correction runs only with the enable set and a real direction code.
  function automatic logic cfg_active(input trim_cfg_t c);
    return c.en && ((c.dir == DIR_DROP) || (c.dir == DIR_ADD));
  endfunction

  // Number of seconds the counter advances for one raw tick.
  function automatic logic [1:0] step_count(input logic corr, input trim_dir_e d);
    if (!corr)            return 2'd1;
    else if (d == DIR_ADD) return 2'd2;
    else                  return 2'd0;
  endfunction

endpackage

// File: rtl/sec_trim_cfg.sv
module sec_trim_cfg
  import sec_trim_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ADJ_OFFSET = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              hit,
  output trim_cfg_t         cfg
);

  assign hit = we && (addr == ADJ_OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (hit) cfg <= unpack_word(wdata);
  end

endmodule

// File: rtl/sec_trim_period.sv
module sec_trim_period #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic             tick,
  input  logic [CNT_W-1:0] match,
  output logic             wrap,
  output logic [CNT_W-1:0] count
);

  logic at_end;
  assign at_end = (count == match);
  assign wrap   = active && tick && at_end && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count <= '0;
    else if (restart || !active) count <= '0;
    else if (tick) begin
      if (at_end) count <= '0;
      else        count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sec_trim_step.sv
module sec_trim_step
  import sec_trim_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      wrap,
  input  trim_dir_e dir,
  output logic      step_one,
  output logic      step_two
);

  logic [1:0] adv;
  assign adv = step_count(wrap, dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_one <= 1'b0;
      step_two <= 1'b0;
    end else begin
      step_one <= tick && (adv == 2'd1);
      step_two <= tick && (adv == 2'd2);
    end
  end

endmodule

// File: rtl/sec_trim_top.sv
module sec_trim_top
  import sec_trim_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADJ_OFFSET = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              adj_we,
  input  logic [ADDR_W-1:0] adj_addr,
  input  logic [31:0]       adj_wdata,
  output logic              step_one,
  output logic              step_two
);

  trim_cfg_t          cfg_q;
  logic               wr_hit;
  logic               trim_act;
  logic               corr_evt;
  logic [MATCH_W-1:0] per_cnt;

  sec_trim_cfg #(.ADDR_W(ADDR_W), .ADJ_OFFSET(ADJ_OFFSET)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (adj_we),
    .addr  (adj_addr),
    .wdata (adj_wdata),
    .hit   (wr_hit),
    .cfg   (cfg_q)
  );

  assign trim_act = cfg_active(cfg_q);

  sec_trim_period #(.CNT_W(MATCH_W)) u_period (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_hit),
    .active  (trim_act),
    .tick    (sec_tick),
    .match   (cfg_q.match),
    .wrap    (corr_evt),
    .count   (per_cnt)
  );

  sec_trim_step u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .wrap     (corr_evt),
    .dir      (cfg_q.dir),
    .step_one (step_one),
    .step_two (step_two)
  );

endmodule

// File: rtl/sec_trim_chk.sv
module sec_trim_chk
  import sec_trim_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sec_tick,
  input logic               step_one,
  input logic               step_two,
  input logic               wr_hit,
  input logic               trim_act,
  input logic               corr_evt,
  input logic [MATCH_W-1:0] per_cnt,
  input trim_cfg_t          cfg_q
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_one, step_two})); // R9

  AST_NO_STEP_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (step_one || step_two) |-> $past(sec_tick)); // R9

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !trim_act) |=> step_one); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    trim_act |-> (per_cnt <= cfg_q.match)); // R7

  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (per_cnt == '0)); // R8

  AST_WRITE_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sec_tick) |=> step_one); // R8

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_evt && cfg_q.dir == DIR_DROP) |=> (!step_one && !step_two)); // R5

  AST_ADD_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_evt && cfg_q.dir == DIR_ADD) |=> step_two); // R6

endmodule

bind sec_trim_top sec_trim_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .step_one (step_one),
  .step_two (step_two),
  .wr_hit   (wr_hit),
  .trim_act (trim_act),
  .corr_evt (corr_evt),
  .per_cnt  (per_cnt),
  .cfg_q    (cfg_q)
);

// File: tb/test_sec_trim_top.sv
`timescale 1ns/100ps
module test_sec_trim_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        adj_we = 1'b0;
  logic [7:0]  adj_addr = '0;
  logic [31:0] adj_wdata = '0;
  logic        step_one, step_two;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sec_trim_top i_sec_trim_top (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .adj_we(adj_we), .adj_addr(adj_addr), .adj_wdata(adj_wdata),
    .step_one(step_one), .step_two(step_two)
  );

  function automatic logic [31:0] mk_word(bit en, logic [1:0] dir, logic [18:0] m);
    return (32'(en) << 23) | (32'(dir) << 19) | 32'(m);
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    adj_we = 1'b1; adj_addr = a; adj_wdata = d;
    @(negedge clk);
    adj_we = 1'b0;
  endtask

  // One tick; returns seconds advanced (one=1, two=2, none=0, both=3 illegal).
  task automatic tick_once(output int adv);
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    adv = step_one ? (step_two ? 3 : 1) : (step_two ? 2 : 0);
    @(negedge clk);
    if (step_one || step_two) adv = 9; // strobe held longer than one cycle
  endtask

  // Independent model: tick i (1-based since write) corrected when i % (m+1) == 0.
  task automatic run_pattern(string req, bit en, logic [1:0] dir, int m, int n);
    int adv, exp;
    wr(8'h18, mk_word(en, dir, 19'(m)));
    for (int i = 1; i <= n; i++) begin
      tick_once(adv);
      exp = 1;
      if (en && dir >= 2 && (i % (m + 1)) == 0) exp = (dir == 2'd3) ? 2 : 0;
      check(req, adv, exp);
    end
  endtask

  task automatic t_reset;
    int adv;
    check("R1 step_one", int'(step_one), 0);
    check("R1 step_two", int'(step_two), 0);
    tick_once(adv);
    check("R1 first tick", adv, 1);
  endtask

  task automatic t_addr_decode;
    int adv;
    wr(8'h18, mk_word(1'b0, 2'd0, 19'd0));
    wr(8'h14, mk_word(1'b1, 2'd2, 19'd0));
    tick_once(adv);
    check("R2 wrong address ignored", adv, 1);
    wr(8'h1C, mk_word(1'b1, 2'd3, 19'd0));
    tick_once(adv);
    check("R2 wrong address ignored", adv, 1);
    // enable placed at bit 22 instead of 23: must stay inactive
    wr(8'h18, 32'h0040_0000 | (32'd3 << 19));
    tick_once(adv);
    check("R2 enable bit position", adv, 1);
    // unrelated high bits set must not matter
    wr(8'h18, 32'hFF00_0000 | mk_word(1'b1, 2'd3, 19'd0));
    tick_once(adv);
    check("R2 other bits ignored", adv, 2);
  endtask

  task automatic t_write_restart;
    int adv;
    wr(8'h18, mk_word(1'b1, 2'd3, 19'd2));
    tick_once(adv); check("R8 pre-rewrite tick1", adv, 1);
    tick_once(adv); check("R8 pre-rewrite tick2", adv, 1);
    wr(8'h18, mk_word(1'b1, 2'd3, 19'd2));
    tick_once(adv); check("R8 restart tick1", adv, 1);
    tick_once(adv); check("R8 restart tick2", adv, 1);
    tick_once(adv); check("R8 restart tick3", adv, 2);
    // coincident write and tick: single step, tick not counted
    @(negedge clk);
    adj_we = 1'b1; adj_addr = 8'h18; adj_wdata = mk_word(1'b1, 2'd2, 19'd1);
    sec_tick = 1'b1;
    @(negedge clk);
    adj_we = 1'b0; sec_tick = 1'b0;
    check("R8 coincident tick", step_one ? 1 : (step_two ? 2 : 0), 1);
    @(negedge clk);
    tick_once(adv); check("R8 after coincident tick1", adv, 1);
    tick_once(adv); check("R8 after coincident tick2", adv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_pattern("R3 disabled", 1'b0, 2'd3, 0, 6);
    run_pattern("R4 code0", 1'b1, 2'd0, 0, 5);
    run_pattern("R4 code1", 1'b1, 2'd1, 1, 5);
    run_pattern("R5 drop m=3", 1'b1, 2'd2, 3, 12);
    run_pattern("R6 insert m=2", 1'b1, 2'd3, 2, 12);
    run_pattern("R7 drop m=0", 1'b1, 2'd2, 0, 5);
    run_pattern("R7 insert m=max", 1'b1, 2'd3, 19'h7FFFF, 40);
    run_pattern("R9 insert m=1", 1'b1, 2'd3, 1, 8);
    t_addr_decode();
    t_write_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule